// File: doc/BRIEF.md
# Pulse-Width Time-Code Decoder

This block decodes a serial time signal in which every second carries one carrier-reduction pulse. A short pulse (about 100 ms) stands for a 0 bit and a long pulse (about 200 ms) for a 1 bit. One second per minute carries no pulse, and the long gap this leaves marks the start of the next minute.

The block takes the demodulated input line and a 1 ms tick. It synchronises the line to the clock and measures the time between consecutive edges in ticks. Each measured interval is sorted into one of three classes: a data bit, a minute marker, or nothing. Data bits are stored in order. On a minute marker the block checks the stored frame. If the frame is complete, the block decodes the BCD calendar and time fields into binary and loads them into a free-running time-of-day counter. That counter then runs on the tick until the next marker.

Top module: `pulse_timecode_decoder`

## Requirements
- R1: The synchronised line is timed in `tickMs` pulses between any two consecutive edges, rising or falling. An edge restarts the count, and a tick in the edge cycle counts as the first tick of the new interval.
- R2: An interval of 51 to 149 ticks stores a 0 at the current bit index and advances the index.
- R3: An interval of 151 to 249 ticks stores a 1 at the current bit index and advances the index.
- R4: An interval of 1001 to 1999 ticks is a minute marker. Every other interval is ignored, including exactly 150, exactly 250, and the 251 to 1000 tick gaps between pulses.
- R5: On a marker with exactly 59 stored bits, the fields are loaded. Each field is BCD, least significant bit first, with weights 1,2,4,8,10,20,40,80. The fields are: minute (7 bits from bit 21), hour (6 from 29), day (6 from 36), weekday (3 from 42), month (5 from 45) and year (8 from 50). Any other bit count loads nothing.
- R6: `timeValid` is high for exactly one cycle each time decoded fields are loaded, and never otherwise.
- R7: Every marker, whether or not it loads, clears the bit index, `second` and `milli`.
- R8: With no marker, each tick advances `milli`. `milli` wraps from 999 into `second`, `second` from 59 into `minute`, `minute` from 59 into `hour`, and `hour` from 23 to 0 while incrementing `day`.
- R9: The bit index saturates after 59 bits. Any further bits are dropped, and a saturated frame does not load.
- R10: The interval count saturates at 2047, so a line with no edges for any length of time is never taken for a marker.
- R11: After reset all time outputs are 0 and `timeValid` is low.
- R12: `rawIn` passes two synchronising flops before edge detection. A marker edge driven on `rawIn` raises `timeValid` three clock edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickMs | input | 1 | One-cycle pulse every millisecond |
| rawIn | input | 1 | Demodulated time-code line, asynchronous |
| timeValid | output | 1 | One-cycle pulse when decoded time is loaded |
| minute | output | 7 | Minute of hour, binary |
| hour | output | 6 | Hour of day, binary |
| day | output | 6 | Day of month, binary |
| weekday | output | 3 | Day of week, binary |
| month | output | 5 | Month, binary |
| year | output | 8 | Year within century, binary |
| second | output | 6 | Second of minute, binary |
| milli | output | 10 | Millisecond of second, binary |

## Verification
Five complete frames are sent, each with its own pulse widths. Two frames place the widths just inside the bit windows (51/151 and 149/249), which separates correct window bounds from bounds that are off by one. A third frame contains one pulse of exactly 150 ticks, so it holds only 58 bits. A fourth frame carries 60 bits. Both of these must leave the previous time untouched, which tells an exact-count decode apart from a loose one. The last frame loads 23:59 and is followed by more than a minute of silence. This exercises the whole wrap chain. It also separates a saturating interval count from a wrapping one, because a wrapping count would read the silence as a marker and clear the milliseconds.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  // Strobes from control to datapath, valid in the cycle an edge is seen.
  typedef struct packed {
    logic storeBit;
    logic bitVal;
    logic marker;
  } tcdStrobe_t;

  // Field layout within a frame: first bit and width.
  localparam int MIN_POS = 21;
  localparam int MIN_LEN = 7;
  localparam int HOUR_POS = 29;
  localparam int HOUR_LEN = 6;
  localparam int DAY_POS = 36;
  localparam int DAY_LEN = 6;
  localparam int WDAY_POS = 42;
  localparam int WDAY_LEN = 3;
  localparam int MON_POS = 45;
  localparam int MON_LEN = 5;
  localparam int YEAR_POS = 50;
  localparam int YEAR_LEN = 8;

endpackage

// File: rtl/tcd_ctrl.sv
module tcd_ctrl #(
  parameter int CNT_W    = 11,
  parameter int ZERO_MIN = 50,
  parameter int ZERO_MAX = 150,
  parameter int ONE_MIN  = 150,
  parameter int ONE_MAX  = 250,
  parameter int MARK_MIN = 1000,
  parameter int MARK_MAX = 2000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickMs,
  input  logic                rawIn,
  output tcd_pkg::tcdStrobe_t strb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] Z_LO = CNT_W'(ZERO_MIN);
  localparam logic [CNT_W-1:0] Z_HI = CNT_W'(ZERO_MAX);
  localparam logic [CNT_W-1:0] O_LO = CNT_W'(ONE_MIN);
  localparam logic [CNT_W-1:0] O_HI = CNT_W'(ONE_MAX);
  localparam logic [CNT_W-1:0] M_LO = CNT_W'(MARK_MIN);
  localparam logic [CNT_W-1:0] M_HI = CNT_W'(MARK_MAX);

  logic [1:0]       syncQ;
  logic             prevQ;
  logic             edgeSeen;
  logic [CNT_W-1:0] intervalCnt;
  logic             isZero, isOne, isMark;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      prevQ <= syncQ[1];
    end
  end

  assign edgeSeen = syncQ[1] ^ prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (edgeSeen) begin
      intervalCnt <= {{(CNT_W-1){1'b0}}, tickMs};
    end else if (tickMs && intervalCnt != CNT_MAX) begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  always_comb begin
    isZero = (intervalCnt > Z_LO) && (intervalCnt < Z_HI);
    isOne  = (intervalCnt > O_LO) && (intervalCnt < O_HI);
    isMark = (intervalCnt > M_LO) && (intervalCnt < M_HI);
    strb.storeBit = edgeSeen && (isZero || isOne);
    strb.bitVal   = isOne;
    strb.marker   = edgeSeen && isMark;
  end

  AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> intervalCnt <= CNT_W'(1)); // R1
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (intervalCnt == CNT_MAX && !edgeSeen) |=> intervalCnt == CNT_MAX); // R10

endmodule

// File: rtl/tcd_data.sv
module tcd_data #(
  parameter int FRAME_BITS = 59,
  parameter int MS_PER_S   = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickMs,
  input  tcd_pkg::tcdStrobe_t strb,
  output logic                timeValid,
  output logic [6:0]          minute,
  output logic [5:0]          hour,
  output logic [5:0]          day,
  output logic [2:0]          weekday,
  output logic [4:0]          month,
  output logic [7:0]          year,
  output logic [5:0]          second,
  output logic [9:0]          milli
);
  import tcd_pkg::*;

  localparam int IDX_W = $clog2(FRAME_BITS + 2);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(FRAME_BITS);
  localparam logic [IDX_W-1:0] IDX_OVER = IDX_W'(FRAME_BITS + 1);
  localparam logic [9:0]       MS_LAST  = 10'(MS_PER_S - 1);

  logic [FRAME_BITS-1:0] frameBits;
  logic [IDX_W-1:0]      bitIdx;
  logic                  loadNow;

  function automatic logic [7:0] bcdField(input logic [FRAME_BITS-1:0] f,
                                          input int startPos, input int len);
    logic [7:0] sum;
    sum = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < len) begin
        if (f[startPos + i]) sum = sum + ((i < 4) ? 8'(1 << i) : 8'(10 << (i - 4)));
      end
    end
    return sum;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameBits <= '0;
      bitIdx    <= '0;
    end else if (strb.marker) begin
      bitIdx <= '0;
    end else if (strb.storeBit && bitIdx != IDX_OVER) begin
      if (bitIdx < IDX_FULL) frameBits[bitIdx] <= strb.bitVal;
      bitIdx <= bitIdx + 1'b1;
    end
  end

  assign loadNow = strb.marker && (bitIdx == IDX_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeValid <= 1'b0;
      minute <= '0; hour <= '0; day <= '0;
      weekday <= '0; month <= '0; year <= '0;
      second <= '0; milli <= '0;
    end else begin
      timeValid <= loadNow;
      if (strb.marker) begin
        milli  <= '0;
        second <= '0;
        if (loadNow) begin
          minute  <= 7'(bcdField(frameBits, MIN_POS, MIN_LEN));
          hour    <= 6'(bcdField(frameBits, HOUR_POS, HOUR_LEN));
          day     <= 6'(bcdField(frameBits, DAY_POS, DAY_LEN));
          weekday <= 3'(bcdField(frameBits, WDAY_POS, WDAY_LEN));
          month   <= 5'(bcdField(frameBits, MON_POS, MON_LEN));
          year    <= bcdField(frameBits, YEAR_POS, YEAR_LEN);
        end
      end else if (tickMs) begin
        if (milli >= MS_LAST) begin
          milli <= '0;
          if (second >= 6'd59) begin
            second <= '0;
            if (minute >= 7'd59) begin
              minute <= '0;
              if (hour >= 6'd23) begin
                hour <= '0;
                day  <= day + 1'b1;
              end else begin
                hour <= hour + 1'b1;
              end
            end else begin
              minute <= minute + 1'b1;
            end
          end else begin
            second <= second + 1'b1;
          end
        end else begin
          milli <= milli + 1'b1;
        end
      end
    end
  end

  AST_LOAD_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    timeValid |-> $past(bitIdx) == IDX_FULL); // R5
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timeValid |=> !timeValid); // R6
  AST_MARK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.marker |=> (milli == '0 && second == '0 && bitIdx == '0)); // R7
  AST_MS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    milli <= MS_LAST); // R8
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bitIdx == IDX_OVER && !strb.marker) |=> bitIdx == IDX_OVER); // R9

endmodule

// File: rtl/pulse_timecode_decoder.sv
module pulse_timecode_decoder #(
  parameter int CNT_W      = 11,
  parameter int ZERO_MIN   = 50,
  parameter int ZERO_MAX   = 150,
  parameter int ONE_MIN    = 150,
  parameter int ONE_MAX    = 250,
  parameter int MARK_MIN   = 1000,
  parameter int MARK_MAX   = 2000,
  parameter int FRAME_BITS = 59,
  parameter int MS_PER_S   = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickMs,
  input  logic       rawIn,
  output logic       timeValid,
  output logic [6:0] minute,
  output logic [5:0] hour,
  output logic [5:0] day,
  output logic [2:0] weekday,
  output logic [4:0] month,
  output logic [7:0] year,
  output logic [5:0] second,
  output logic [9:0] milli
);
  tcd_pkg::tcdStrobe_t strb;

  tcd_ctrl #(
    .CNT_W(CNT_W), .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
    .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX),
    .MARK_MIN(MARK_MIN), .MARK_MAX(MARK_MAX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .rawIn(rawIn), .strb(strb)
  );

  tcd_data #(
    .FRAME_BITS(FRAME_BITS), .MS_PER_S(MS_PER_S)
  ) u_data (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .strb(strb),
    .timeValid(timeValid), .minute(minute), .hour(hour), .day(day),
    .weekday(weekday), .month(month), .year(year),
    .second(second), .milli(milli)
  );

endmodule

// File: tb/pulse_timecode_decoder_tb.sv
module pulse_timecode_decoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickMs = 1'b0;
  logic rawIn = 1'b0;
  logic timeValid;
  logic [6:0] minute;
  logic [5:0] hour, day, second;
  logic [2:0] weekday;
  logic [4:0] month;
  logic [7:0] year;
  logic [9:0] milli;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam int GAP  = 251;
  localparam int MARK = 1500;

  typedef struct packed {
    logic [7:0] mi, hr, dy, wd, mo, yr, zw, ow, drop;
    logic [1:0] extra;
    logic       load;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'd34, 8'd12, 8'd17, 8'd3, 8'd8,  8'd24, 8'd51,  8'd151, 8'd255, 2'd0, 1'b1},
    '{8'd7,  8'd5,  8'd31, 8'd7, 8'd12, 8'd99, 8'd149, 8'd249, 8'd255, 2'd0, 1'b1},
    '{8'd45, 8'd20, 8'd1,  8'd1, 8'd1,  8'd0,  8'd100, 8'd200, 8'd10,  2'd0, 1'b0},
    '{8'd12, 8'd1,  8'd2,  8'd2, 8'd2,  8'd2,  8'd100, 8'd200, 8'd255, 2'd1, 1'b0},
    '{8'd59, 8'd23, 8'd5,  8'd4, 8'd6,  8'd30, 8'd60,  8'd160, 8'd255, 2'd0, 1'b1}
  };

  pulse_timecode_decoder u_dut (
    .clk(clk), .rstN(rstN), .tickMs(tickMs), .rawIn(rawIn),
    .timeValid(timeValid), .minute(minute), .hour(hour), .day(day),
    .weekday(weekday), .month(month), .year(year),
    .second(second), .milli(milli)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [59:0] buildFrame(input vec_t v);
    logic [59:0] f;
    logic [7:0] b;
    f = '0;
    b = toBcd(int'(v.mi)); for (int i = 0; i < 7; i++) f[21 + i] = b[i];
    b = toBcd(int'(v.hr)); for (int i = 0; i < 6; i++) f[29 + i] = b[i];
    b = toBcd(int'(v.dy)); for (int i = 0; i < 6; i++) f[36 + i] = b[i];
    b = toBcd(int'(v.wd)); for (int i = 0; i < 3; i++) f[42 + i] = b[i];
    b = toBcd(int'(v.mo)); for (int i = 0; i < 5; i++) f[45 + i] = b[i];
    b = toBcd(int'(v.yr)); for (int i = 0; i < 8; i++) f[50 + i] = b[i];
    return f;
  endfunction

  // Sends all bits of a frame and ends with the marker edge; rawIn is high on entry.
  task automatic sendFrame(input vec_t v);
    logic [59:0] f;
    int nBits;
    int w;
    f = buildFrame(v);
    nBits = 59 + int'(v.extra);
    for (int b = 0; b < nBits; b++) begin
      w = f[b] ? int'(v.ow) : int'(v.zw);
      if (b == int'(v.drop)) w = 150;
      rawIn = 1'b1;
      repeat (w) @(negedge clk);
      rawIn = 1'b0;
      repeat ((b == nBits - 1) ? MARK : GAP) @(negedge clk);
    end
    rawIn = 1'b1;
  endtask

  initial begin
    int expMi, expHr, expDy, expWd, expMo, expYr;
    int firstHigh, highCnt;
    tickMs = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 minute after reset", int'(minute), 0);
    chk("R11 milli after reset", int'(milli), 0);
    chk("R11 timeValid after reset", int'(timeValid), 0);
    rstN = 1'b1;

    // opening marker: low gap then rising edge, nothing stored yet
    repeat (MARK) @(negedge clk);
    rawIn = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 R6 opening marker loads nothing", int'(timeValid), 0);
    chkRange("R7 opening marker clears milli", int'(milli), 0, 5);
    expMi = 0; expHr = 0; expDy = 0; expWd = 0; expMo = 0; expYr = 0;

    for (int v = 0; v < 5; v++) begin
      sendFrame(VECS[v]);
      firstHigh = 0; highCnt = 0;
      for (int k = 1; k <= 6; k++) begin
        @(negedge clk);
        if (timeValid) begin
          highCnt++;
          if (firstHigh == 0) firstHigh = k;
        end
      end
      if (VECS[v].load) begin
        expMi = int'(VECS[v].mi); expHr = int'(VECS[v].hr); expDy = int'(VECS[v].dy);
        expWd = int'(VECS[v].wd); expMo = int'(VECS[v].mo); expYr = int'(VECS[v].yr);
        chk("R12 marker-to-valid latency", firstHigh, 3);
      end
      chk("R6 R5 R9 valid pulse count", highCnt, VECS[v].load ? 1 : 0);
      chk("R1 R2 R3 R5 minute", int'(minute), expMi);
      chk("R1 R2 R3 R5 hour", int'(hour), expHr);
      chk("R2 R3 R5 day", int'(day), expDy);
      chk("R2 R3 R5 weekday", int'(weekday), expWd);
      chk("R2 R3 R5 month", int'(month), expMo);
      chk("R2 R3 R5 year", int'(year), expYr);
      chk("R7 second cleared by marker", int'(second), 0);
      chkRange("R7 milli cleared by marker", int'(milli), 0, 5);
    end

    // Last frame loaded 23:59; idle for over a minute with no edges.
    repeat (60894) @(negedge clk);
    chk("R8 minute wraps", int'(minute), 0);
    chk("R8 hour wraps", int'(hour), 0);
    chk("R8 day increments", int'(day), 6);
    chk("R8 second wraps", int'(second), 0);
    chkRange("R8 milli runs", int'(milli), 890, 905);
    // R10: a wrapping count would read this edge as a marker
    rawIn = 1'b0;
    repeat (6) @(negedge clk);
    chkRange("R10 long idle is not a marker", int'(milli), 895, 915);
    chk("R10 no load after long idle", int'(timeValid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule